// File: doc/BRIEF.md
# Bitstream Ones-Count Sampler

This block turns a one-bit oversampled stream, arriving at one bit per system clock from a first-order sigma-delta modulator, into multi-bit samples. Over a window whose length in clocks is set by a programmable period, it counts how many ones arrived. At the end of each window it publishes that count as the newest sample and raises a ready flag. The host reads the sample and clears the flag with a one-cycle acknowledge strobe.

The block runs only when its five-bit mode input selects the counting function and its direction/run input is high. Any other mode, a low run input or the synchronous reset holds every register at zero. The window length need not be a power of two, so a period of clock rate divided by sample rate gives the wanted output rate directly. A period value of zero selects the longest window, 2^PERIOD_W clocks.

Top module: `sdc_sample_counter`

## Requirements
- R1: The block counts only while `mode_sel` equals 5'b11000. With any other mode value it is held cleared, so `sample_z` reads 0 and `sample_flag` reads 0.
- R2: While `dir_run` is low, or `rst` is high, the window position, the running count, `sample_z` and `sample_flag` are cleared. A window cut short this way is discarded.
- R3: Each sample equals the number of ones among the `period_x` consecutive stream bits of its window. It appears on `sample_z` after the clock edge that takes in the last bit of that window.
- R4: Windows follow each other with no gap. Every stream bit belongs to exactly one sample.
- R5: A `period_x` of 0 sets a window of 2^PERIOD_W clocks.
- R6: The count never wraps. A stream of all ones yields a sample equal to the window length, including 2^PERIOD_W, which is why `sample_z` is PERIOD_W+1 bits wide.
- R7: `sample_flag` goes high on the edge that publishes a sample. An `ack` pulse in a cycle with no new sample clears it. An `ack` in the same cycle as a new sample leaves it high.
- R8: The first sample after the block starts running covers a full window, beginning with the bit present at the first running clock edge.
- R9: `sample_z` keeps its value between publications, whether or not `ack` is pulsed.
- R10: A new sample overwrites `sample_z` even if the previous one was never acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one stream bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 5 | Function select; 5'b11000 enables counting |
| period_x | input | PERIOD_W | Window length in clocks; 0 means 2^PERIOD_W |
| dir_run | input | 1 | High runs the block, low holds it cleared |
| ack | input | 1 | One-cycle strobe that clears the ready flag |
| bit_in | input | 1 | Sigma-delta bitstream |
| sample_z | output | PERIOD_W+1 | Most recent completed count of ones |
| sample_flag | output | 1 | High when a sample has been published and not yet acknowledged |

## Verification
The stream comes from a behavioural first-order modulator at input levels of 0, full scale, half scale and several uneven fractions. A 16-bit LFSR supplies irregular streams. The constant levels separate exact edge counts: zero, the full window and the half-window. The uneven levels and the LFSR, taken over window lengths of 1, prime numbers, 255 and 0 (meaning 256), expose off-by-one window boundaries and lost or double-counted bits between consecutive samples. Directed runs abort a window by dropping the run input, select a foreign mode, and place the acknowledge before, together with, and never alongside a publication. These runs separate clearing, flag precedence and overwrite behaviour.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // Mode code that selects the ones-counting sampler.
  localparam logic [4:0] MODE_ONES_COUNT = 5'b11000;

  // Window length with zero mapped to the longest window.
  function automatic logic [31:0] window_len(input logic [31:0] x, input int unsigned w);
    return (x == 32'd0) ? (32'd1 << w) : x;
  endfunction
endpackage

// File: rtl/sdc_gate.sv
module sdc_gate
  import sdc_pkg::*;
(
  input  logic       rst,
  input  logic [4:0] mode_sel,
  input  logic       dir_run,
  output logic       run
);
  // Counting runs only out of reset, with run high and the right mode.
  always_comb run = !rst && dir_run && (mode_sel == MODE_ONES_COUNT);
endmodule

// File: rtl/sdc_accum.sv
module sdc_accum #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period_x,
  input  logic                bit_in,
  output logic                done,
  output logic [PERIOD_W:0]   total
);
  localparam int CNT_W = PERIOD_W + 1;

  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] win_len;
  logic [CNT_W-1:0] phase_nxt;
  logic             last_bit;

  always_comb begin
    win_len   = (period_x == '0) ? (CNT_W'(1) << PERIOD_W) : {1'b0, period_x};
    phase_nxt = phase + CNT_W'(1);
    last_bit  = (phase_nxt >= win_len);
    done      = run && last_bit;
    total     = ones + {{(CNT_W-1){1'b0}}, bit_in};
  end

  always_ff @(posedge clk) begin
    if (!run) begin
      phase <= '0;
      ones  <= '0;
    end else if (last_bit) begin
      phase <= '0;
      ones  <= '0;
    end else begin
      phase <= phase_nxt;
      ones  <= total;
    end
  end

  // R6: the running count can never exceed the bits taken in so far
  assert_count_within_phase_R6: assert property (@(posedge clk) disable iff (rst)
    ones <= phase);

  // R2: a stopped block restarts its window from nothing
  assert_idle_clears_window_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == '0 && ones == '0));
endmodule

// File: rtl/sdc_sample_reg.sv
module sdc_sample_reg #(
  parameter int PERIOD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load,
  input  logic [PERIOD_W:0] value,
  input  logic              ack,
  output logic [PERIOD_W:0] z,
  output logic              flag
);
  always_ff @(posedge clk) begin
    if (!run) begin
      z    <= '0;
      flag <= 1'b0;
    end else begin
      if (load) z <= value;
      flag <= load || (flag && !ack);
    end
  end

  // R7: publication raises the flag, even with a simultaneous ack
  assert_flag_on_publish_R7: assert property (@(posedge clk) disable iff (rst)
    (run && load) |=> flag);

  // R7: an ack with nothing new drops the flag
  assert_ack_clears_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && !load) |=> !flag);

  // R9: the sample holds between publications while running
  assert_sample_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(load)) |-> $stable(z));
endmodule

// File: rtl/sdc_sample_counter.sv
module sdc_sample_counter
  import sdc_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [4:0]          mode_sel,
  input  logic [PERIOD_W-1:0] period_x,
  input  logic                dir_run,
  input  logic                ack,
  input  logic                bit_in,
  output logic [PERIOD_W:0]   sample_z,
  output logic                sample_flag
);
  localparam int CNT_W = PERIOD_W + 1;

  logic             run;
  logic             done;
  logic [CNT_W-1:0] total;

  sdc_gate u_gate (
    .rst      (rst),
    .mode_sel (mode_sel),
    .dir_run  (dir_run),
    .run      (run)
  );

  sdc_accum #(.PERIOD_W(PERIOD_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .period_x (period_x),
    .bit_in   (bit_in),
    .done     (done),
    .total    (total)
  );

  sdc_sample_reg #(.PERIOD_W(PERIOD_W)) u_sample (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .load  (done),
    .value (total),
    .ack   (ack),
    .z     (sample_z),
    .flag  (sample_flag)
  );

  // R1: a foreign mode leaves the outputs cleared
  assert_foreign_mode_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != MODE_ONES_COUNT) |=> (sample_z == '0 && !sample_flag));

  // R6: a freshly published sample fits within its window
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_flag) |-> (32'(sample_z) <= window_len(32'($past(period_x)), PERIOD_W)));
endmodule

// File: tb/test_sdc_sample_counter.sv
module test_sdc_sample_counter;
  localparam int PW = 8;
  localparam logic [4:0] MODE_ON = 5'b11000;

  // Vector fields: [31:24] period, [23:16] source (0 modulator, 1 LFSR), [15:0] level or seed
  localparam logic [31:0] VECS [9] = '{
    {8'd10,  8'd0, 16'd0},
    {8'd10,  8'd0, 16'd256},
    {8'd16,  8'd0, 16'd128},
    {8'd37,  8'd0, 16'd77},
    {8'd200, 8'd0, 16'd200},
    {8'd23,  8'd1, 16'hACE1},
    {8'd1,   8'd0, 16'd128},
    {8'd255, 8'd1, 16'h1234},
    {8'd0,   8'd0, 16'd256}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    mode_sel;
  logic [PW-1:0] period_x;
  logic          dir_run;
  logic          ack;
  logic          bit_in;
  logic [PW:0]   sample_z;
  logic          sample_flag;

  int nvec = 0;
  int nerr = 0;
  int src_kind;
  int level;
  int macc;
  logic [15:0] lfsr;

  always #2.5 clk = ~clk;

  sdc_sample_counter #(.PERIOD_W(PW)) i_sdc_sample_counter (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .period_x(period_x),
    .dir_run(dir_run), .ack(ack), .bit_in(bit_in),
    .sample_z(sample_z), .sample_flag(sample_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gen_bit(output logic b);
    if (src_kind == 0) begin
      macc = macc + level;
      if (macc >= 256) begin b = 1'b1; macc = macc - 256; end
      else b = 1'b0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[0];
    end
  endtask

  // Called at a falling edge; drives n bits and returns at the falling edge after the last.
  task automatic feed(input int n, input int ack_at, output int ones);
    logic b;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      gen_bit(b);
      bit_in = b;
      ack = (i == ack_at);
      ones += int'(b);
      @(negedge clk);
    end
    ack = 1'b0;
  endtask

  task automatic restart(input int per);
    dir_run = 1'b0;
    period_x = PW'(per);
    @(negedge clk);
    @(negedge clk);
    dir_run = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int ones;
    int ones2;
    rst = 1'b1; mode_sel = MODE_ON; period_x = PW'(10);
    dir_run = 1'b0; ack = 1'b0; bit_in = 1'b0;
    src_kind = 0; level = 0; macc = 0; lfsr = 16'h1;
    repeat (3) @(negedge clk);
    check("R2 reset sample", int'(sample_z), 0);
    check("R2 reset flag", int'(sample_flag), 0);
    rst = 1'b0;

    // Table walk: two consecutive windows per vector
    for (int v = 0; v < 9; v++) begin
      int per;
      int eff;
      per = int'(VECS[v][31:24]);
      eff = (per == 0) ? 256 : per;
      src_kind = int'(VECS[v][23:16]);
      level = int'(VECS[v][15:0]);
      lfsr = VECS[v][15:0];
      macc = 0;
      restart(per);
      feed(eff, -1, ones);
      check(per == 0 ? "R5 R8 first window" : "R3 R8 first window", int'(sample_z), ones);
      check("R7 flag after first", int'(sample_flag), 1);
      feed(eff, 0, ones);
      check(level == 256 ? "R6 R4 second window" : "R4 second window", int'(sample_z), ones);
      check("R7 flag after second", int'(sample_flag), 1);
    end

    // Ack handling and hold
    src_kind = 0; level = 256; macc = 0;
    restart(12);
    feed(12, -1, ones);
    check("R6 all ones", int'(sample_z), 12);
    feed(4, 0, ones);
    check("R7 ack clears flag", int'(sample_flag), 0);
    check("R9 sample held after ack", int'(sample_z), 12);
    feed(8, 7, ones2);
    check("R7 ack with publish keeps flag", int'(sample_flag), 1);
    check("R4 window split across ack", int'(sample_z), ones + ones2);

    // Overwrite without acknowledge
    level = 0;
    feed(12, -1, ones);
    check("R10 overwrite unacked", int'(sample_z), 0);
    check("R10 flag stays", int'(sample_flag), 1);

    // Foreign mode
    dir_run = 1'b0;
    @(negedge clk);
    mode_sel = 5'b00110; dir_run = 1'b1; level = 256;
    feed(24, -1, ones);
    check("R1 foreign mode sample", int'(sample_z), 0);
    check("R1 foreign mode flag", int'(sample_flag), 0);
    mode_sel = MODE_ON;
    feed(12, -1, ones);
    check("R1 R8 counting after mode select", int'(sample_z), 12);

    // Window aborted by run low
    feed(5, -1, ones);
    dir_run = 1'b0;
    @(negedge clk);
    check("R2 run low clears sample", int'(sample_z), 0);
    check("R2 run low clears flag", int'(sample_flag), 0);
    dir_run = 1'b1; level = 0;
    feed(7, -1, ones);
    check("R2 aborted window discarded", int'(sample_flag), 0);
    feed(5, -1, ones);
    check("R2 R8 full window after abort", int'(sample_flag), 1);
    check("R2 count after abort", int'(sample_z), 0);

    // Synchronous reset in mid-run
    level = 256;
    feed(12, -1, ones);
    rst = 1'b1;
    @(negedge clk);
    check("R2 rst clears sample", int'(sample_z), 0);
    check("R2 rst clears flag", int'(sample_flag), 0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule